// File: doc/BRIEF.md
# Dual-Tone Sine Synthesizer with Per-Tone Gain

This block produces one stream of signed 16-bit samples for a single converter channel. The stream is the sum of two sine tones. Each tone has its own phase accumulator, a programmable step that sets its frequency, a programmable start phase and a signed gain. The accumulator width `PHASE_W` is chosen when the block is built, from 16 to 32 bits. Step and start values arrive as a low 16-bit word and a high 16-bit word, so software can program accumulators wider than 16 bits. The block reports its accumulator width on a read-only 6-bit output, and software uses that value to work out the step for a target frequency: step = f_out × 2^PHASE_W × clock_ratio / f_if.

On every cycle where `sample_en` is high, the block takes the current phase of both tones. The upper bits of each phase address a quarter-wave sine table, with the full wave rebuilt by quadrant folding. Each sine value is multiplied by its gain, and the two products are added and clipped to 16 bits. Pulling `synth_off` high mutes the output and holds both accumulators at their start phases, so no frequency, phase or gain setting reaches the output.

Top module: `tone_pair_synth`

## Requirements
- R1: `width_code` always equals `PHASE_W`. This includes the reset state.
- R2: A tone's full step is `{step_hi, step_lo}` truncated to `PHASE_W` bits. When `PHASE_W` is 16, `step_hi` is ignored. On every clock edge where `sample_en` is high and no reload happens, the accumulator adds its full step modulo 2^PHASE_W. When `sample_en` is low, the accumulator holds.
- R3: Both accumulators reload to their full start phases (`{start_hi, start_lo}` truncated to `PHASE_W`) on a clock edge in either of two cases: `resync` is high and was low at the previous edge, or either tone's full start phase differs from its value at the previous edge. After reset, the previous values count as zero. Holding `resync` high does not cause further reloads.
- R4: A sample taken at a clock edge uses each accumulator's value before that edge's update. The top `LUT_ABITS+2` phase bits give a quadrant q (upper two bits) and an index i. For q=0 the sine value is +T[i], for q=1 it is +T[N-1-i], for q=2 it is −T[i] and for q=3 it is −T[N-1-i]. Here N = 2^LUT_ABITS and T[k] = round(32767·sin((k+0.5)·π/(2N))).
- R5: Each gain is signed with 14 fractional bits and one integer bit, so 0x4000 is unity. Each tone contributes (sine × gain) shifted right arithmetically by 14 bits, which rounds toward minus infinity. The gain used is the one present when the sample enters the output stage.
- R6: The sum of the two contributions saturates to 32767 or −32768 and never wraps. Two unity gains on in-phase peaks give 32767, and on in-phase troughs they give −32768.
- R7: `out_valid` is high in the cycle after the third rising edge, counting the edge that sampled `sample_en` high as the first. `out_sample` keeps its value in every cycle where `out_valid` is low.
- R8: A sample taken while `synth_off` is high is 0. While `synth_off` is high, both accumulators are loaded with their start phases at every edge, so changes to steps or gains made in that time do not affect any output.
- R9: After reset, `out_valid` is 0, `out_sample` is 0 and both accumulators are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| synth_off | input | 1 | Mutes output and pins accumulators to start phases |
| sample_en | input | 1 | Take one sample at this edge |
| resync | input | 1 | Rising level reloads both accumulators |
| a_step_lo | input | 16 | Tone A step, low word |
| a_step_hi | input | 16 | Tone A step, high word |
| a_start_lo | input | 16 | Tone A start phase, low word |
| a_start_hi | input | 16 | Tone A start phase, high word |
| a_gain | input | 16 | Tone A gain, signed 1.1.14 |
| b_step_lo | input | 16 | Tone B step, low word |
| b_step_hi | input | 16 | Tone B step, high word |
| b_start_lo | input | 16 | Tone B start phase, low word |
| b_start_hi | input | 16 | Tone B start phase, high word |
| b_gain | input | 16 | Tone B gain, signed 1.1.14 |
| width_code | output | 6 | Accumulator width PHASE_W |
| out_sample | output | 16 | Signed summed sample |
| out_valid | output | 1 | Marks a new sample |

## Verification
A sample taken at an edge appears with `out_valid` after the third edge, counting the sampling edge as the first. Reloads and step additions take effect at the same edge that sees their cause. The driver advances a reference model once per edge, working from the inputs that edge will see, and pushes one expected sample into a queue for every edge with `sample_en` high. The monitor pops one entry on each falling edge where `out_valid` is high, so a latency error shows up as a misaligned sample. Gains are held steady for the two edges that follow the last sample of each stimulus group, because the output stage reads the gain live. Direct checks confirm the three-edge timing of a single isolated sample, that `out_sample` holds while `out_valid` is low, and the two saturation limits.

// File: rtl/tps_pkg.sv
`timescale 1ns/1ps
package tps_pkg;
   localparam int SAMPLE_W = 16;
   localparam int GAIN_FRAC = 14;
   localparam int SUM_W = SAMPLE_W + 3;

   typedef logic signed [SAMPLE_W-1:0] sample_t;

   // Clip a widened sum into the signed sample range.
   function automatic sample_t clip_sample(input logic signed [SUM_W-1:0] v);
      if (v > SUM_W'(32767))
         return 16'sh7FFF;
      else if (v < -SUM_W'(32768))
         return 16'sh8000;
      else
         return v[SAMPLE_W-1:0];
   endfunction
endpackage

// File: rtl/tps_phase_acc.sv
`timescale 1ns/1ps
module tps_phase_acc #(
   parameter int PHASE_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               advance,
   input  logic [15:0]        step_lo,
   input  logic [15:0]        step_hi,
   input  logic [15:0]        start_lo,
   input  logic [15:0]        start_hi,
   output logic [PHASE_W-1:0] phase,
   output logic [PHASE_W-1:0] step_full,
   output logic [PHASE_W-1:0] start_full
);
   generate
      if (PHASE_W == 16) begin : g_narrow
         logic unused_hi;
         assign unused_hi  = ^{step_hi, start_hi};
         assign step_full  = step_lo;
         assign start_full = start_lo;
      end else begin : g_wide
         assign step_full  = PHASE_W'({step_hi, step_lo});
         assign start_full = PHASE_W'({start_hi, start_lo});
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (load)
         phase <= start_full;
      else if (advance)
         phase <= phase + step_full;
   end
endmodule

// File: rtl/tps_quarter_rom.sv
`timescale 1ns/1ps
module tps_quarter_rom
   import tps_pkg::*;
#(
   parameter int LUT_ABITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LUT_ABITS+1:0] addr,
   output sample_t              wave
);
   localparam int  N  = 1 << LUT_ABITS;
   localparam real PI = 3.14159265358979323846;

   logic [14:0] tbl [N];

   for (genvar k = 0; k < N; k++) begin : g_tab
      localparam real ANG = (real'(k) + 0.5) * PI / (2.0 * real'(N));
      assign tbl[k] = 15'($rtoi($sin(ANG) * 32767.0 + 0.5));
   end

   logic [1:0]           quad;
   logic [LUT_ABITS-1:0] idx;
   logic [15:0]          mag;

   always_comb begin
      quad = addr[LUT_ABITS+1:LUT_ABITS];
      idx  = quad[0] ? ~addr[LUT_ABITS-1:0] : addr[LUT_ABITS-1:0];
      mag  = {1'b0, tbl[idx]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wave <= '0;
      else
         wave <= quad[1] ? -$signed(mag) : $signed(mag);
   end
endmodule

// File: rtl/tps_mix.sv
`timescale 1ns/1ps
module tps_mix
   import tps_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    in_valid,
   input  logic    in_off,
   input  sample_t tone_a,
   input  sample_t tone_b,
   input  sample_t gain_a,
   input  sample_t gain_b,
   output sample_t mix,
   output logic    mix_valid
);
   localparam int PROD_W = 2 * SAMPLE_W;
   localparam int PART_W = SUM_W - 1;

   logic signed [PROD_W-1:0] prod_a, prod_b;
   logic signed [PART_W-1:0] part_a, part_b;
   logic signed [SUM_W-1:0]  total;

   always_comb begin
      prod_a = PROD_W'(tone_a) * PROD_W'(gain_a);
      prod_b = PROD_W'(tone_b) * PROD_W'(gain_b);
      part_a = PART_W'(prod_a >>> GAIN_FRAC);
      part_b = PART_W'(prod_b >>> GAIN_FRAC);
      total  = SUM_W'(part_a) + SUM_W'(part_b);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mix       <= '0;
         mix_valid <= 1'b0;
      end else begin
         mix_valid <= in_valid;
         if (in_valid)
            mix <= in_off ? '0 : clip_sample(total);
      end
   end
endmodule

// File: rtl/tone_pair_synth.sv
`timescale 1ns/1ps
module tone_pair_synth
   import tps_pkg::*;
#(
   parameter int PHASE_W   = 24,
   parameter int LUT_ABITS = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        synth_off,
   input  logic        sample_en,
   input  logic        resync,
   input  logic [15:0] a_step_lo,
   input  logic [15:0] a_step_hi,
   input  logic [15:0] a_start_lo,
   input  logic [15:0] a_start_hi,
   input  logic [15:0] a_gain,
   input  logic [15:0] b_step_lo,
   input  logic [15:0] b_step_hi,
   input  logic [15:0] b_start_lo,
   input  logic [15:0] b_start_hi,
   input  logic [15:0] b_gain,
   output logic [5:0]  width_code,
   output logic [15:0] out_sample,
   output logic        out_valid
);
   localparam int TONES = 2;
   localparam int ADR_W = LUT_ABITS + 2;

   if (PHASE_W < 16 || PHASE_W > 32) begin : g_bad_width
      $error("PHASE_W must lie in 16..32");
   end
   if (ADR_W > PHASE_W || LUT_ABITS < 2) begin : g_bad_lut
      $error("LUT_ABITS out of range for PHASE_W");
   end

   assign width_code = 6'(PHASE_W);

   logic [TONES-1:0][15:0]        step_lo_v, step_hi_v, start_lo_v, start_hi_v;
   logic [TONES-1:0][PHASE_W-1:0] phase, step_full, start_full, prev_start;
   logic [TONES-1:0][ADR_W-1:0]   s1_addr;
   sample_t                       wave [TONES];
   logic                          resync_q, reload;
   logic                          s1_valid, s1_off, s2_valid, s2_off;
   sample_t                       mix_out;

   assign step_lo_v  = {b_step_lo,  a_step_lo};
   assign step_hi_v  = {b_step_hi,  a_step_hi};
   assign start_lo_v = {b_start_lo, a_start_lo};
   assign start_hi_v = {b_start_hi, a_start_hi};

   assign reload = synth_off || (resync && !resync_q) || (start_full != prev_start);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resync_q   <= 1'b0;
         prev_start <= '0;
         s1_valid   <= 1'b0;
         s1_off     <= 1'b0;
         s2_valid   <= 1'b0;
         s2_off     <= 1'b0;
         s1_addr    <= '0;
      end else begin
         resync_q   <= resync;
         prev_start <= start_full;
         s1_valid   <= sample_en;
         s1_off     <= synth_off;
         s2_valid   <= s1_valid;
         s2_off     <= s1_off;
         if (sample_en)
            for (int t = 0; t < TONES; t++)
               s1_addr[t] <= phase[t][PHASE_W-1 -: ADR_W];
      end
   end

   for (genvar t = 0; t < TONES; t++) begin : g_tone
      tps_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
         .clk        (clk),
         .rst_n      (rst_n),
         .load       (reload),
         .advance    (sample_en),
         .step_lo    (step_lo_v[t]),
         .step_hi    (step_hi_v[t]),
         .start_lo   (start_lo_v[t]),
         .start_hi   (start_hi_v[t]),
         .phase      (phase[t]),
         .step_full  (step_full[t]),
         .start_full (start_full[t])
      );
      tps_quarter_rom #(.LUT_ABITS(LUT_ABITS)) u_rom (
         .clk   (clk),
         .rst_n (rst_n),
         .addr  (s1_addr[t]),
         .wave  (wave[t])
      );
   end

   tps_mix u_mix (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (s2_valid),
      .in_off    (s2_off),
      .tone_a    (wave[0]),
      .tone_b    (wave[1]),
      .gain_a    (a_gain),
      .gain_b    (b_gain),
      .mix       (mix_out),
      .mix_valid (out_valid)
   );
   assign out_sample = mix_out;
endmodule

// File: rtl/tps_checker.sv
`timescale 1ns/1ps
module tps_checker #(
   parameter int PHASE_W = 24
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sample_en,
   input logic               synth_off,
   input logic               reload,
   input logic               out_valid,
   input logic [15:0]        out_sample,
   input logic [PHASE_W-1:0] acc_a,
   input logic [PHASE_W-1:0] step_a,
   input logic [PHASE_W-1:0] start_a
);
   logic [1:0] age;
   logic       warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end
   assign warm = (age == 2'd3);

   // R7: sample appears after three edges
   a_r7_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> (out_valid == $past(sample_en, 3)));

   // R7: output holds between samples
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && !out_valid) |-> $stable(out_sample));

   // R8: muted samples are zero
   a_r8_muted_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && $past(sample_en && synth_off, 3)) |-> (out_sample == 16'h0000));

   // R3: reload lands the start phase
   a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && $past(reload)) |-> (acc_a == $past(start_a)));

   // R2: step added modulo 2^PHASE_W
   a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && $past(sample_en && !reload))
         |-> (acc_a == PHASE_W'($past(acc_a) + $past(step_a))));

   // R2: idle accumulator holds
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && $past(!sample_en && !reload)) |-> $stable(acc_a));
endmodule

bind tone_pair_synth tps_checker #(.PHASE_W(PHASE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sample_en  (sample_en),
   .synth_off  (synth_off),
   .reload     (reload),
   .out_valid  (out_valid),
   .out_sample (out_sample),
   .acc_a      (phase[0]),
   .step_a     (step_full[0]),
   .start_a    (start_full[0])
);

// File: tb/sim_tone_pair_synth.sv
`timescale 1ns/1ps
module sim_tone_pair_synth;
   localparam int W  = 24;
   localparam int AB = 8;
   localparam int N  = 1 << AB;
   localparam real PI = 3.14159265358979323846;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, synth_off, sample_en, resync;
   logic [15:0] a_step_lo, a_step_hi, a_start_lo, a_start_hi, a_gain;
   logic [15:0] b_step_lo, b_step_hi, b_start_lo, b_start_hi, b_gain;
   logic [5:0]  width_code;
   logic signed [15:0] out_sample;
   logic        out_valid;

   tone_pair_synth #(.PHASE_W(W), .LUT_ABITS(AB)) u0 (
      .clk(clk), .rst_n(rst_n), .synth_off(synth_off), .sample_en(sample_en),
      .resync(resync),
      .a_step_lo(a_step_lo), .a_step_hi(a_step_hi),
      .a_start_lo(a_start_lo), .a_start_hi(a_start_hi), .a_gain(a_gain),
      .b_step_lo(b_step_lo), .b_step_hi(b_step_hi),
      .b_start_lo(b_start_lo), .b_start_hi(b_start_hi), .b_gain(b_gain),
      .width_code(width_code), .out_sample(out_sample), .out_valid(out_valid));

   int checks = 0;
   int fails  = 0;
   int    exp_q [$];
   string tag_q [$];
   logic [W-1:0] m_acc_a, m_acc_b, m_prev_a, m_prev_b;
   logic         m_rsq;

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int sine_ref(logic [W-1:0] ph);
      logic [AB+1:0]  top = ph[W-1 -: AB+2];
      logic [AB-1:0]  idx = top[AB] ? ~top[AB-1:0] : top[AB-1:0];
      real ang = (real'(idx) + 0.5) * PI / (2.0 * real'(N));
      int mag = $rtoi($sin(ang) * 32767.0 + 0.5);
      return top[AB+1] ? -mag : mag;
   endfunction

   function automatic int mix_ref();
      int pa = sine_ref(m_acc_a) * int'($signed(a_gain));
      int pb = sine_ref(m_acc_b) * int'($signed(b_gain));
      int s  = (pa >>> 14) + (pb >>> 14);
      if (s > 32767)  s = 32767;
      if (s < -32768) s = -32768;
      return s;
   endfunction

   // Driver: advance the model for the coming edge, then wait for it.
   task automatic tick(string tag);
      logic [W-1:0] sa = W'({a_start_hi, a_start_lo});
      logic [W-1:0] sb = W'({b_start_hi, b_start_lo});
      logic rl = synth_off || (resync && !m_rsq) || sa != m_prev_a || sb != m_prev_b;
      if (sample_en) begin
         exp_q.push_back(synth_off ? 0 : mix_ref());
         tag_q.push_back(tag);
      end
      if (rl) begin
         m_acc_a = sa; m_acc_b = sb;
      end else if (sample_en) begin
         m_acc_a = m_acc_a + W'({a_step_hi, a_step_lo});
         m_acc_b = m_acc_b + W'({b_step_hi, b_step_lo});
      end
      m_rsq = resync; m_prev_a = sa; m_prev_b = sb;
      @(negedge clk);
   endtask

   task automatic idle(int n);
      sample_en = 1'b0;
      for (int i = 0; i < n; i++) tick("idle");
   endtask

   // Monitor: compare each produced sample with the queue head.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            check("R7 unexpected sample", 1, 0);
         end else begin
            automatic int    e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(t, int'(out_sample), e);
         end
      end
   end

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      int held;
      rst_n = 1'b0; synth_off = 1'b0; sample_en = 1'b0; resync = 1'b0;
      a_step_lo = 0; a_step_hi = 0; a_start_lo = 0; a_start_hi = 0; a_gain = 0;
      b_step_lo = 0; b_step_hi = 0; b_start_lo = 0; b_start_hi = 0; b_gain = 0;
      m_acc_a = 0; m_acc_b = 0; m_prev_a = 0; m_prev_b = 0; m_rsq = 0;
      repeat (4) @(negedge clk);
      check("R9 out_valid at reset", int'(out_valid), 0);
      check("R9 out_sample at reset", int'(out_sample), 0);
      check("R1 width_code", int'(width_code), W);
      rst_n = 1'b1;
      @(negedge clk);

      // R2/R4: tone A alone at unity, high word bits above W dropped
      a_step_hi = 16'hFF01; a_step_lo = 16'h2345; a_gain = 16'h4000;
      idle(2);
      sample_en = 1'b1;
      for (int i = 0; i < 40; i++) tick("R4 tone A unity");
      idle(6);

      // R5: mixed signed gains, gapped sampling
      a_gain = 16'h2000; b_gain = 16'hE000;
      b_step_hi = 16'h0003; b_step_lo = 16'h9ABC;
      idle(2);
      for (int i = 0; i < 30; i++) begin
         sample_en = (i % 2 == 0);
         tick("R5 mixed gains");
      end
      idle(6);

      // R3: resync rising edge and start-phase change reload
      sample_en = 1'b1;
      for (int i = 0; i < 30; i++) begin
         resync = (i >= 10 && i < 13);
         if (i == 20) a_start_lo = 16'h1000;
         tick("R3 reload");
      end
      resync = 1'b0;
      idle(6);

      // R6: saturation at both limits
      a_gain = 16'h4000; b_gain = 16'h4000;
      a_step_hi = 0; a_step_lo = 0; b_step_hi = 0; b_step_lo = 0;
      a_start_hi = 16'h0040; a_start_lo = 0; b_start_hi = 16'h0040; b_start_lo = 0;
      idle(2);
      sample_en = 1'b1;
      for (int i = 0; i < 4; i++) tick("R6 positive clip");
      idle(5);
      check("R6 positive limit", int'(out_sample), 32767);
      a_start_hi = 16'h00C0; b_start_hi = 16'h00C0;
      idle(2);
      sample_en = 1'b1;
      for (int i = 0; i < 4; i++) tick("R6 negative clip");
      idle(5);
      check("R6 negative limit", int'(out_sample), -32768);

      // R8: muted, setting changes have no effect
      a_step_lo = 16'h0800; b_step_lo = 16'h0500;
      a_start_hi = 16'h0010; b_start_hi = 16'h0020;
      a_gain = 16'h3000; b_gain = 16'h1000;
      idle(2);
      synth_off = 1'b1; sample_en = 1'b1;
      for (int i = 0; i < 12; i++) begin
         if (i == 4) begin a_step_lo = 16'h7777; a_gain = 16'h7FFF; end
         tick("R8 muted");
      end
      idle(6);
      check("R8 muted output", int'(out_sample), 0);
      a_gain = 16'h3000;
      idle(2);
      synth_off = 1'b0; sample_en = 1'b1;
      for (int i = 0; i < 16; i++) tick("R8 restart from start phase");
      idle(6);

      // R7: single-sample latency and hold
      sample_en = 1'b1;
      tick("R7 single");
      sample_en = 1'b0;
      check("R7 valid after edge 1", int'(out_valid), 0);
      tick("idle");
      check("R7 valid after edge 2", int'(out_valid), 0);
      tick("idle");
      check("R7 valid after edge 3", int'(out_valid), 1);
      held = int'(out_sample);
      idle(4);
      check("R7 output held", int'(out_sample), held);
      check("R7 valid low while idle", int'(out_valid), 0);

      check("R7 queue drained", exp_q.size(), 0);
      report();
   end
endmodule